// File: doc/BRIEF.md
# Fuse Array Access Sequencer

This block sits between a simple register port and a small one-time-programmable fuse array, which is modelled here as a bank of flops. Software picks one fuse word by bank and word index. It can then sense the word from the array or program it. It can also read and override a shadow copy of every word. Sense and program each run as a timed strobe. A relax interval comes before the strobe and another comes after it. All three lengths come from a timing register and are counted in clock cycles.

Programming takes effect only when a 16-bit unlock key is present in the control register. A rejected operation sets a sticky error flag and leaves the array untouched. Rejected operations are: a program without the key, an address beyond the array, or any new command issued while the sequencer is busy. The error flag is cleared through a separate clear alias. After reset, a loader copies every array word into its shadow, and the busy flag stays high for the whole copy.

Top module: `fuse_ctl`

## Requirements
- R1: During reset and for the shadow load after it (one cycle per word, 32 words by default), busy reads 1. Afterwards CTRL (0x00) reads 0, and TIMING (0x02) reads 0x0007100F. At reset, array word i holds the value i, and each shadow holds a copy of its array word.
- R2: CTRL (0x00) bit layout. Bits 6:0 hold the fuse address. Bit 8 is busy, bit 9 is error, and bits 31:16 hold the unlock field. All other bits read 0, and a read returns the written address and key.
- R3: The fuse address is bank*8 + word. The last valid word is 31. A sense or program with an address of 32 or more sets the error flag and does not start.
- R4: Writing a value with bit 0 set to RCMD (0x04) starts a sense. Busy then stays high for read-count+1 cycles, and the sensed word is readable at RDATA (0x05) once busy is low.
- R5: The strobe output stays low for the first relax+1 cycles of busy and high for the next count+1-2*(relax+1) cycles. It is low again for the last relax+1 cycles, and it is never high while busy is low.
- R6: Writing WDATA (0x03) starts a program only when CTRL bits 31:16 equal 0x3E77. With any other key value, the error flag is set, busy stays low and the word keeps its value.
- R7: A program ORs the WDATA value into the addressed word, and busy stays high for program-count+1 cycles.
- R8: Writing WDATA or RCMD while busy sets the error flag. The running operation still completes with its own result.
- R9: While busy, writes to CTRL, TIMING and WDATA have no effect on the stored values.
- R10: The error flag stays set until a write to CLR (0x01) with bit 9 set. A CLR write with bit 9 clear leaves the flag set.
- R11: Shadow word i is read and written at 0x40+i. A shadow write does not change the array, and a program does not update the shadow.
- R12: TIMING (0x02) bit layout. Bits 21:16 hold the read count, bits 15:12 the relax count and bits 11:0 the program count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| busy | output | 1 | Sequencer or shadow loader active |
| fuse_strobe | output | 1 | Strobe pulse applied to the fuse array |

## Verification
A command write is captured on one rising edge, and busy reads high from that edge. Busy then stays high for exactly count+1 cycles. The bench drives each write across a full cycle between falling edges. It then samples busy and the strobe on every later falling edge, so the measured busy and strobe lengths can be compared directly with count+1 and count+1-2*(relax+1). Error and register effects are visible one edge after the write. They are read back at the falling edge that ends the write. Sensed data is read only once busy has been seen low, which is the cycle after the final count.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam int ADDR_W     = 7;
  localparam int KEY_W      = 16;
  localparam int RD_W       = 6;
  localparam int RLX_W      = 4;
  localparam int PG_W       = 12;
  localparam int BANK_SHIFT = 3;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_CLR   = 8'h01;
  localparam logic [7:0] OFF_TIME  = 8'h02;
  localparam logic [7:0] OFF_WDATA = 8'h03;
  localparam logic [7:0] OFF_RCMD  = 8'h04;
  localparam logic [7:0] OFF_RDATA = 8'h05;
  localparam logic [1:0] SHADOW_TAG = 2'b01;

  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SENSE = 2'd1,
    OP_PROG  = 2'd2
  } op_e;
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int DEF_RD    = 7,
  parameter int DEF_RELAX = 1,
  parameter int DEF_PG    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [KEY_W-1:0]  unlock,
  output logic              err,
  output logic [RD_W-1:0]   rd_cnt,
  output logic [RLX_W-1:0]  relax_cnt,
  output logic [PG_W-1:0]   pg_cnt,
  output logic [31:0]       prog_data,
  output logic              start,
  output op_e               start_op,
  output logic              shadow_wr
);
  logic hit_ctrl, hit_clr, hit_time, cmd_prog, cmd_sense, cmd_any;
  logic addr_bad, reject;
  logic ctrl_en, time_en, data_en;
  logic err_d;

  always_comb begin
    hit_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
    hit_clr   = reg_wr && (reg_addr == OFF_CLR);
    hit_time  = reg_wr && (reg_addr == OFF_TIME);
    cmd_prog  = reg_wr && (reg_addr == OFF_WDATA);
    cmd_sense = reg_wr && (reg_addr == OFF_RCMD) && reg_wdata[0];
    cmd_any   = cmd_prog || cmd_sense;
    addr_bad  = (int'(fuse_addr) >= NUM_WORDS);
    reject    = cmd_any && (busy || addr_bad ||
                            (cmd_prog && (unlock != UNLOCK_KEY)));
    start     = cmd_any && !reject;
    start_op  = cmd_prog ? OP_PROG : OP_SENSE;
    ctrl_en   = hit_ctrl && !busy;
    time_en   = hit_time && !busy;
    data_en   = cmd_prog && !busy;
    shadow_wr = reg_wr && !busy && (reg_addr[7:6] == SHADOW_TAG) &&
                (int'(reg_addr[5:0]) < NUM_WORDS);
    if (reject)
      err_d = 1'b1;
    else if (hit_clr && reg_wdata[9])
      err_d = 1'b0;
    else
      err_d = err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_addr <= '0;
      unlock    <= '0;
    end else if (ctrl_en) begin
      fuse_addr <= reg_wdata[ADDR_W-1:0];
      unlock    <= reg_wdata[31:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt    <= RD_W'(DEF_RD);
      relax_cnt <= RLX_W'(DEF_RELAX);
      pg_cnt    <= PG_W'(DEF_PG);
    end else if (time_en) begin
      rd_cnt    <= reg_wdata[21:16];
      relax_cnt <= reg_wdata[15:12];
      pg_cnt    <= reg_wdata[11:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prog_data <= '0;
    else if (data_en)
      prog_data <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err <= 1'b0;
    else
      err <= err_d;
  end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_op,
  input  logic [RD_W-1:0]  rd_cnt,
  input  logic [RLX_W-1:0] relax_cnt,
  input  logic [PG_W-1:0]  pg_cnt,
  output logic             busy,
  output logic             strobe,
  output logic             done,
  output op_e              done_op
);
  logic            busy_d;
  logic [PG_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [RLX_W-1:0] rlx_q;
  op_e             op_q;
  logic [PG_W:0]   edge_len, cnt_wide;

  always_comb begin
    done     = busy && (cnt_q == lim_q);
    done_op  = op_q;
    busy_d   = start ? 1'b1 : (done ? 1'b0 : busy);
    if (start)
      cnt_d = '0;
    else if (busy && !done)
      cnt_d = cnt_q + PG_W'(1);
    else
      cnt_d = cnt_q;
    lim_d    = (start_op == OP_PROG) ? pg_cnt : PG_W'(rd_cnt);
    edge_len = (PG_W+1)'(rlx_q) + (PG_W+1)'(1);
    cnt_wide = {1'b0, cnt_q};
    strobe   = busy && (cnt_wide >= edge_len) &&
               ((cnt_wide + edge_len) <= {1'b0, lim_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      rlx_q <= '0;
      op_q  <= OP_NONE;
    end else if (start) begin
      lim_q <= lim_d;
      rlx_q <= relax_cnt;
      op_q  <= start_op;
    end
  end
endmodule

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int IW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  op_e           done_op,
  input  logic [IW-1:0] word_idx,
  input  logic [31:0]   prog_data,
  input  logic          shadow_wr,
  input  logic [IW-1:0] shadow_idx,
  input  logic [31:0]   shadow_wdata,
  output logic [31:0]   sense_data,
  output logic          loading,
  output logic [31:0]   shadow_rdata
);
  logic [31:0]   fuse_vals [NUM_WORDS];
  logic [31:0]   shad_vals [NUM_WORDS];
  logic [IW-1:0] ld_idx, ld_idx_d;
  logic          ld_d, sense_en;

  always_comb begin
    ld_d     = loading && (ld_idx != IW'(NUM_WORDS - 1));
    ld_idx_d = loading ? ld_idx + IW'(1) : ld_idx;
    sense_en = done && (done_op == OP_SENSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b1;
      ld_idx  <= '0;
    end else begin
      loading <= ld_d;
      ld_idx  <= ld_idx_d;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] fuse_q, fuse_d, shad_q, shad_d;
    logic        fuse_en, shad_en;

    always_comb begin
      fuse_en = done && (done_op == OP_PROG) && (word_idx == IW'(w));
      fuse_d  = fuse_q | prog_data;
      shad_en = (loading && (ld_idx == IW'(w))) ||
                (shadow_wr && (shadow_idx == IW'(w)));
      shad_d  = loading ? fuse_q : shadow_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fuse_q <= 32'(w);
      else if (fuse_en)
        fuse_q <= fuse_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shad_q <= '0;
      else if (shad_en)
        shad_q <= shad_d;
    end

    assign fuse_vals[w] = fuse_q;
    assign shad_vals[w] = shad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sense_data <= '0;
    else if (sense_en)
      sense_data <= fuse_vals[word_idx];
  end

  assign shadow_rdata = shad_vals[shadow_idx];
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_ctl_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int DEF_RD    = 7,
  parameter int DEF_RELAX = 1,
  parameter int DEF_PG    = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        fuse_strobe
);
  localparam int NUM_WORDS = BANKS << BANK_SHIFT;
  localparam int IW        = $clog2(NUM_WORDS);

  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [ADDR_W-1:0] fuse_addr;
  logic [KEY_W-1:0]  unlock;
  logic              err, start, shadow_wr;
  op_e               start_op, done_op;
  logic [RD_W-1:0]   rd_cnt;
  logic [RLX_W-1:0]  relax_cnt;
  logic [PG_W-1:0]   pg_cnt;
  logic [31:0]       prog_data, sense_data, shadow_rdata;
  logic              seq_busy, done, loading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  fuse_regs #(
    .NUM_WORDS(NUM_WORDS), .DEF_RD(DEF_RD),
    .DEF_RELAX(DEF_RELAX), .DEF_PG(DEF_PG)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .fuse_addr(fuse_addr),
    .unlock(unlock), .err(err), .rd_cnt(rd_cnt), .relax_cnt(relax_cnt),
    .pg_cnt(pg_cnt), .prog_data(prog_data), .start(start),
    .start_op(start_op), .shadow_wr(shadow_wr)
  );

  fuse_seq u_seq (
    .clk(clk), .rst_n(rst_n_i), .start(start), .start_op(start_op),
    .rd_cnt(rd_cnt), .relax_cnt(relax_cnt), .pg_cnt(pg_cnt),
    .busy(seq_busy), .strobe(fuse_strobe), .done(done), .done_op(done_op)
  );

  fuse_store #(.NUM_WORDS(NUM_WORDS), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n_i), .done(done), .done_op(done_op),
    .word_idx(fuse_addr[IW-1:0]), .prog_data(prog_data),
    .shadow_wr(shadow_wr), .shadow_idx(reg_addr[IW-1:0]),
    .shadow_wdata(reg_wdata), .sense_data(sense_data),
    .loading(loading), .shadow_rdata(shadow_rdata)
  );

  assign busy = seq_busy || loading;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_CTRL || reg_addr == OFF_CLR)
      reg_rdata = {unlock, 6'b0, err, busy, 1'b0, fuse_addr};
    else if (reg_addr == OFF_TIME)
      reg_rdata = {10'b0, rd_cnt, relax_cnt, pg_cnt};
    else if (reg_addr == OFF_WDATA)
      reg_rdata = prog_data;
    else if (reg_addr == OFF_RDATA)
      reg_rdata = sense_data;
    else if (reg_addr[7:6] == SHADOW_TAG && int'(reg_addr[5:0]) < NUM_WORDS)
      reg_rdata = shadow_rdata;
  end
endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk
  import fuse_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              err,
  input logic              seq_busy,
  input logic              start,
  input logic              fuse_strobe,
  input logic [ADDR_W-1:0] fuse_addr,
  input logic [31:0]       sense_data
);
  // R5
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> seq_busy);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(reg_wr));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(reg_wr && (reg_addr == OFF_CLR) && reg_wdata[9]));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> $stable(fuse_addr));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> seq_busy);

  // R4
  sense_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sense_data) |-> ($past(seq_busy) && !seq_busy));
endmodule

bind fuse_ctl fuse_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .err(err), .seq_busy(seq_busy), .start(start),
  .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr), .sense_data(sense_data)
);

// File: tb/fuse_ctl_test.sv
`timescale 1ns/1ps
module fuse_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        busy;
  logic        fuse_strobe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  fuse_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .fuse_strobe(fuse_strobe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic time_busy(output int bc, output int sc);
    bc = 0; sc = 0;
    while (busy && bc < 5000) begin
      bc++;
      if (fuse_strobe) sc++;
      @(negedge clk);
    end
  endtask

  task automatic sense(input logic [6:0] a, output logic [31:0] d, output int bc, output int sc);
    wr(8'h00, {16'h0000, 9'b0, a});
    wr(8'h04, 32'h1);
    time_busy(bc, sc);
    rd(8'h05, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, 32'd1);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R1 load length in range", {31'b0, (n >= 32 && n <= 37)}, 32'd1);
    rd(8'h00, d); check("R1 ctrl after reset", d, 32'h0);
    rd(8'h02, d); check("R1 R12 timing default", d, 32'h0007100F);
    rd(8'h40, d); check("R1 shadow 0", d, 32'h0);
    rd(8'h5F, d); check("R1 shadow 31", d, 32'd31);
  endtask

  task automatic t_sense_default();
    logic [31:0] d;
    int bc, sc;
    sense(7'd11, d, bc, sc);  // R3 bank 1 word 3
    check("R4 sense busy cycles", bc, 32'd8);
    check("R5 strobe cycles", sc, 32'd4);
    check("R4 R3 sensed preset", d, 32'h0B);
    sense(7'd31, d, bc, sc);
    check("R3 last word sense", d, 32'd31);
  endtask

  task automatic t_prog_locked();
    logic [31:0] d;
    int bc, sc;
    wr(8'h00, 32'h1234_000B);
    wr(8'h03, 32'hFFFF_0000);
    check("R6 no busy without key", {31'b0, busy}, 32'd0);
    rd(8'h00, d); check("R6 R2 error set", d, 32'h1234_020B);
    wr(8'h01, 32'h0);
    rd(8'h00, d); check("R10 clear bit9 low keeps err", d[9], 32'd1);
    wr(8'h01, 32'h200);
    rd(8'h00, d); check("R10 clear alias", d[9], 32'd0);
    sense(7'd11, d, bc, sc);
    check("R6 word unchanged", d, 32'h0B);
  endtask

  task automatic t_prog_ok();
    logic [31:0] d;
    int bc, sc;
    wr(8'h00, 32'h3E77_000B);
    rd(8'h00, d); check("R2 ctrl readback", d, 32'h3E77_000B);
    wr(8'h03, 32'h0000_00F0);
    time_busy(bc, sc);
    check("R7 program busy cycles", bc, 32'd16);
    check("R5 program strobe cycles", sc, 32'd12);
    wr(8'h03, 32'h0F00_0001);
    time_busy(bc, sc);
    sense(7'd11, d, bc, sc);
    check("R7 OR accumulate", d, 32'h0F00_00FB);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    int bc, sc;
    wr(8'h02, 32'h0014_3028);
    rd(8'h02, d); check("R12 timing readback", d, 32'h0014_3028);
    sense(7'd5, d, bc, sc);
    check("R4 busy with new count", bc, 32'd21);
    check("R5 strobe with relax 3", sc, 32'd13);
    check("R4 sensed word 5", d, 32'd5);
  endtask

  task automatic t_busy_cmds();
    logic [31:0] d;
    int bc, sc;
    wr(8'h00, 32'h0000_0006);
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h1);
    wr(8'h00, 32'h3E77_0009);
    wr(8'h02, 32'h0);
    wr(8'h03, 32'hAAAA_AAAA);
    time_busy(bc, sc);
    rd(8'h00, d); check("R8 R9 err set, ctrl held", d, 32'h0000_0206);
    rd(8'h02, d); check("R9 timing held", d, 32'h0014_3028);
    rd(8'h03, d); check("R9 wdata held", d, 32'h0F00_0001);
    rd(8'h05, d); check("R8 first sense result", d, 32'd6);
    wr(8'h01, 32'h200);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(8'h00, 32'h3E77_002A);  // R3 bank 5 word 2 = 42
    wr(8'h03, 32'h1);
    check("R3 out of range no busy", {31'b0, busy}, 32'd0);
    rd(8'h00, d); check("R3 out of range err", d[9], 32'd1);
    wr(8'h01, 32'h200);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    int bc, sc;
    rd(8'h4B, d); check("R11 shadow not updated by program", d, 32'h0B);
    wr(8'h4B, 32'hDEAD_BEEF);
    rd(8'h4B, d); check("R11 shadow override", d, 32'hDEAD_BEEF);
    rd(8'h4C, d); check("R11 neighbour shadow", d, 32'h0C);
    sense(7'd11, d, bc, sc);
    check("R11 array untouched", d, 32'h0F00_00FB);
  endtask

  initial begin
    t_reset();
    t_sense_default();
    t_prog_locked();
    t_prog_ok();
    t_timing();
    t_busy_cmds();
    t_range();
    t_shadow();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule